// File: doc/BRIEF.md
# System Coprocessor Exception and Interrupt Controller

This block keeps the exception state of a MIPS-style system coprocessor: the Status word, the Cause word, the exception return address (EPC) and the error return address (ErrorEPC). Each cycle it decides whether an external or software interrupt must be taken. It performs exception entry and exception return. On entry it saves the return address, the delay-slot flag and the cause code, raises the exception level and picks a vector. On return it sends fetch back to the saved address. The pipeline around it supplies the current PC and requests synchronous exceptions and ERET. The pipeline reads back redirect targets and an LL-bit clear strobe.

Eight request lines feed the pending-interrupt field of Cause. Line 7 carries the timer. Lines 0 and 1 can also be raised by software, by writing Cause. An exception taken while the exception level is already raised only updates the cause code. This keeps the first return address intact. The vector base depends on the boot-vector bit in Status.

Top module: `cp0_exc_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until the first other event, Status reads 0x0040_0000 (only bit 22, the boot-vector bit, set), Cause reads 0, redirectPc holds 0xFFFFFFFF_BFC00000, and redirectValid, llClear and irqPending are 0.
- R2: Each clock, Cause bits 15:8 (IP) take irqLines OR'ed with the two software bits in positions 9:8. The new value is readable one cycle after the lines are sampled. A Cause write changes only the software bits (data bits 9:8); all other data bits are ignored.
- R3: irqPending is 1 exactly when Status bits 2:0 (ERL, EXL, IE) equal 3'b001 and Cause IP AND Status bits 15:8 (IM) is nonzero. It follows the registered state in the same cycle.
- R4: On entry with Status bit 1 (EXL) clear, EPC takes curPc and Cause bit 31 takes excInDelay. Cause bits 6:2 take the code, IP is kept, and EXL is set. All of this is visible the next cycle.
- R5: On entry with EXL already set, EPC and Cause bit 31 are unchanged, the code field is updated and EXL stays set.
- R6: In the cycle after an entry, redirectValid is 1 for one cycle. redirectPc is 0xFFFFFFFF_BFC00380 if Status bit 22 was set, else 0xFFFFFFFF_80000180.
- R7: A pending interrupt with no excReq and no eretReq is taken as an entry with code 0 and delay flag 0. excReq in the same cycle wins over a pending interrupt. After entry, irqPending reads 0.
- R8: On eretReq with Status bit 2 (ERL) set, ERL is cleared and redirectPc takes ErrorEPC. Otherwise EXL is cleared and redirectPc takes EPC. In the next cycle redirectValid and llClear pulse for one cycle.
- R9: If excReq and eretReq come in the same cycle, the exception is taken and the return is ignored (no llClear, exception vector).
- R10: regWrSel selects the write target: 0 Status (bits 31:0), 1 Cause, 2 EPC, 3 ErrorEPC. A write is visible the next cycle and is dropped in a cycle that performs an entry or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 8 | Interrupt request lines, line 7 is the timer |
| excReq | input | 1 | Synchronous exception request |
| excCode | input | 5 | Exception code for excReq |
| excInDelay | input | 1 | Faulting instruction sits in a delay slot |
| curPc | input | PC_W | PC of the current instruction |
| eretReq | input | 1 | Exception return request |
| regWrEn | input | 1 | Register write enable |
| regWrSel | input | 2 | Register write select |
| regWrData | input | PC_W | Register write data |
| redirectPc | output | PC_W | Fetch redirect target |
| redirectValid | output | 1 | One-cycle redirect strobe |
| irqPending | output | 1 | An enabled interrupt is pending |
| llClear | output | 1 | Clear the load-linked bit |
| statusOut | output | 32 | Status register |
| causeOut | output | 32 | Cause register |
| epcOut | output | PC_W | Exception return address |
| errorEpcOut | output | PC_W | Error return address |

## Verification
A wrong IE/EXL/ERL or mask decode shows in the next cycle as a wrong irqPending level. The sweep over every line pattern, mask set and mode combination exposes it. A wrong EPC or delay-flag update stays hidden until the return, when redirectPc points to the wrong address. The bench therefore checks the registers right after each entry and again through the ERET target. Priority faults show one cycle later as the wrong cause code, or as an llClear pulse where none belongs.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
  localparam int IRQ_N        = 8;
  localparam int SW_IRQ_N     = 2;
  localparam int CODE_W       = 5;
  localparam int ST_IE        = 0;
  localparam int ST_EXL       = 1;
  localparam int ST_ERL       = 2;
  localparam int ST_IM_LO     = 8;
  localparam int ST_BEV       = 22;
  localparam int CA_CODE_LO   = 2;
  localparam int CA_IP_LO     = 8;
  localparam int CA_BD        = 31;
  localparam logic [CODE_W-1:0] CODE_INT = '0;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_ERREPC = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              enter;
    logic [CODE_W-1:0] code;
    logic              inDelay;
    logic              eret;
    logic              wrStatus;
    logic              wrCause;
    logic              wrEpc;
    logic              wrErrEpc;
  } cp0Strobe_t;
endpackage

// File: rtl/cp0_ctrl.sv
module cp0_ctrl
  import cp0_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic              excInDelay,
  input  logic              eretReq,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [31:0]       statusQ,
  input  logic [31:0]       causeQ,
  output cp0Strobe_t        str,
  output logic              irqPending
);
  logic [IRQ_N-1:0] enabledIrq;
  logic             modeOk;
  logic             busy;

  always_comb begin
    enabledIrq = statusQ[ST_IM_LO +: IRQ_N] & causeQ[CA_IP_LO +: IRQ_N];
    modeOk     = (statusQ[ST_ERL:ST_IE] == 3'b001);
    irqPending = modeOk && (|enabledIrq);

    str = '0;
    if (excReq) begin
      str.enter   = 1'b1;
      str.code    = excCode;
      str.inDelay = excInDelay;
    end else if (eretReq) begin
      str.eret = 1'b1;
    end else if (irqPending) begin
      str.enter = 1'b1;
      str.code  = CODE_INT;
    end

    busy = str.enter | str.eret;
    if (regWrEn && !busy) begin
      case (regSel_e'(regWrSel))
        SEL_STATUS: str.wrStatus = 1'b1;
        SEL_CAUSE:  str.wrCause  = 1'b1;
        SEL_EPC:    str.wrEpc    = 1'b1;
        default:    str.wrErrEpc = 1'b1;
      endcase
    end
  end

  // R7: an unopposed pending interrupt raises the exception level next cycle
  assert_int_taken_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !excReq && !eretReq) |=> statusQ[ST_EXL]);

  // R9: a synchronous exception beside a return still leaves EXL raised
  assert_exc_beats_eret_R9: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && eretReq) |=> statusQ[ST_EXL]);
endmodule

// File: rtl/cp0_dp.sv
module cp0_dp
  import cp0_pkg::*;
#(
  parameter int              PC_W      = 64,
  parameter logic [PC_W-1:0] BOOT_PC   = 64'hFFFF_FFFF_BFC0_0000,
  parameter logic [PC_W-1:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
  parameter logic [PC_W-1:0] GEN_BASE  = 64'hFFFF_FFFF_8000_0000,
  parameter logic [PC_W-1:0] VEC_OFS   = 64'h180
) (
  input  logic             clk,
  input  logic             rstN,
  input  cp0Strobe_t       str,
  input  logic [IRQ_N-1:0] irqLines,
  input  logic [PC_W-1:0]  curPc,
  input  logic [PC_W-1:0]  wrData,
  output logic [31:0]      statusQ,
  output logic [31:0]      causeQ,
  output logic [PC_W-1:0]  epcQ,
  output logic [PC_W-1:0]  errEpcQ,
  output logic [PC_W-1:0]  redirectPc,
  output logic             redirectValid,
  output logic             llClear
);
  localparam logic [PC_W-1:0] BEV_VEC = BOOT_BASE + VEC_OFS;
  localparam logic [PC_W-1:0] GEN_VEC = GEN_BASE + VEC_OFS;
  localparam logic [31:0]     ST_RESET = 32'(1) << ST_BEV;

  logic [CODE_W-1:0]   codeQ;
  logic                bdQ;
  logic [IRQ_N-1:0]    ipQ;
  logic [SW_IRQ_N-1:0] swIpQ;
  logic [SW_IRQ_N-1:0] swIpD;

  assign causeQ = {bdQ, 15'b0, ipQ, 1'b0, codeQ, 2'b0};
  assign swIpD  = str.wrCause ? wrData[CA_IP_LO +: SW_IRQ_N] : swIpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swIpQ <= '0;
      ipQ   <= '0;
    end else begin
      swIpQ <= swIpD;
      ipQ   <= irqLines | {{(IRQ_N-SW_IRQ_N){1'b0}}, swIpD};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ       <= ST_RESET;
      codeQ         <= '0;
      bdQ           <= 1'b0;
      epcQ          <= '0;
      errEpcQ       <= '0;
      redirectPc    <= BOOT_PC;
      redirectValid <= 1'b0;
      llClear       <= 1'b0;
    end else begin
      redirectValid <= 1'b0;
      llClear       <= 1'b0;
      if (str.enter) begin
        if (!statusQ[ST_EXL]) begin
          epcQ <= curPc;
          bdQ  <= str.inDelay;
        end
        codeQ            <= str.code;
        statusQ[ST_EXL]  <= 1'b1;
        redirectPc       <= statusQ[ST_BEV] ? BEV_VEC : GEN_VEC;
        redirectValid    <= 1'b1;
      end else if (str.eret) begin
        if (statusQ[ST_ERL]) begin
          statusQ[ST_ERL] <= 1'b0;
          redirectPc      <= errEpcQ;
        end else begin
          statusQ[ST_EXL] <= 1'b0;
          redirectPc      <= epcQ;
        end
        redirectValid <= 1'b1;
        llClear       <= 1'b1;
      end else begin
        if (str.wrStatus) statusQ <= wrData[31:0];
        if (str.wrEpc)    epcQ    <= wrData;
        if (str.wrErrEpc) errEpcQ <= wrData;
      end
    end
  end

  // R4: entry always leaves the exception level raised
  assert_exl_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    str.enter |=> statusQ[ST_EXL]);

  // R4: fresh entry copies the delay-slot flag
  assert_bd_copy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (str.enter && !statusQ[ST_EXL]) |=> (causeQ[CA_BD] == $past(str.inDelay)));

  // R5: nested entry keeps the first return address
  assert_epc_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (str.enter && statusQ[ST_EXL]) |=> $stable(epcQ));

  // R6: a redirect only follows an entry or a return
  assert_redirect_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(str.enter || str.eret));

  // R8: the LL clear pulse only follows a return
  assert_ll_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    llClear |-> $past(str.eret));
endmodule

// File: rtl/cp0_exc_ctrl.sv
module cp0_exc_ctrl
  import cp0_pkg::*;
#(
  parameter int              PC_W      = 64,
  parameter logic [PC_W-1:0] BOOT_PC   = 64'hFFFF_FFFF_BFC0_0000,
  parameter logic [PC_W-1:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
  parameter logic [PC_W-1:0] GEN_BASE  = 64'hFFFF_FFFF_8000_0000,
  parameter logic [PC_W-1:0] VEC_OFS   = 64'h180
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        irqLines,
  input  logic              excReq,
  input  logic [4:0]        excCode,
  input  logic              excInDelay,
  input  logic [PC_W-1:0]   curPc,
  input  logic              eretReq,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [PC_W-1:0]   regWrData,
  output logic [PC_W-1:0]   redirectPc,
  output logic              redirectValid,
  output logic              irqPending,
  output logic              llClear,
  output logic [31:0]       statusOut,
  output logic [31:0]       causeOut,
  output logic [PC_W-1:0]   epcOut,
  output logic [PC_W-1:0]   errorEpcOut
);
  cp0Strobe_t  strobe;
  logic [31:0] statusQ;
  logic [31:0] causeQ;

  cp0_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .excReq     (excReq),
    .excCode    (excCode),
    .excInDelay (excInDelay),
    .eretReq    (eretReq),
    .regWrEn    (regWrEn),
    .regWrSel   (regWrSel),
    .statusQ    (statusQ),
    .causeQ     (causeQ),
    .str        (strobe),
    .irqPending (irqPending)
  );

  cp0_dp #(
    .PC_W      (PC_W),
    .BOOT_PC   (BOOT_PC),
    .BOOT_BASE (BOOT_BASE),
    .GEN_BASE  (GEN_BASE),
    .VEC_OFS   (VEC_OFS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .str           (strobe),
    .irqLines      (irqLines),
    .curPc         (curPc),
    .wrData        (regWrData),
    .statusQ       (statusQ),
    .causeQ        (causeQ),
    .epcQ          (epcOut),
    .errEpcQ       (errorEpcOut),
    .redirectPc    (redirectPc),
    .redirectValid (redirectValid),
    .llClear       (llClear)
  );

  assign statusOut = statusQ;
  assign causeOut  = causeQ;
endmodule

// File: tb/cp0_exc_ctrl_tb.sv
module cp0_exc_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  irqLines;
  logic        excReq;
  logic [4:0]  excCode;
  logic        excInDelay;
  logic [63:0] curPc;
  logic        eretReq;
  logic        regWrEn;
  logic [1:0]  regWrSel;
  logic [63:0] regWrData;
  logic [63:0] redirectPc;
  logic        redirectValid;
  logic        irqPending;
  logic        llClear;
  logic [31:0] statusOut;
  logic [31:0] causeOut;
  logic [63:0] epcOut;
  logic [63:0] errorEpcOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  localparam logic [63:0] GEN_V = 64'hFFFF_FFFF_8000_0180;
  localparam logic [63:0] BEV_V = 64'hFFFF_FFFF_BFC0_0380;

  always #10 clk = ~clk;

  cp0_exc_ctrl u_dut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .excReq(excReq),
    .excCode(excCode), .excInDelay(excInDelay), .curPc(curPc),
    .eretReq(eretReq), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .redirectPc(redirectPc),
    .redirectValid(redirectValid), .irqPending(irqPending),
    .llClear(llClear), .statusOut(statusOut), .causeOut(causeOut),
    .epcOut(epcOut), .errorEpcOut(errorEpcOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [63:0] data);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    step();
    regWrEn = 1'b0;
  endtask

  function automatic logic [4:0] codeOf(input logic [31:0] c);
    return c[6:2];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; irqLines = '0; excReq = 1'b0; excCode = '0; excInDelay = 1'b0;
    curPc = '0; eretReq = 1'b0; regWrEn = 1'b0; regWrSel = '0; regWrData = '0;
    repeat (3) step();
    chk("R1 status in reset", 64'(statusOut), 64'h0040_0000);
    rstN = 1'b1;
    step();
    chk("R1 status", 64'(statusOut), 64'h0040_0000);
    chk("R1 cause", 64'(causeOut), 64'h0);
    chk("R1 boot pc", redirectPc, 64'hFFFF_FFFF_BFC0_0000);
    chk("R1 valid", 64'(redirectValid), 64'h0);
    chk("R1 pending", 64'(irqPending), 64'h0);
    chk("R1 llClear", 64'(llClear), 64'h0);

    // R2: IP field tracks lines, software bits only from a Cause write
    irqLines = 8'hA5;
    step();
    chk("R2 ip follows lines", 64'(causeOut), 64'h0000_A500);
    wrReg(2'd1, 64'hFFFF_FFFF);
    chk("R2 software bits only", 64'(causeOut), 64'h0000_A700);
    irqLines = 8'h00;
    wrReg(2'd1, 64'h0);
    chk("R2 software bits cleared", 64'(causeOut), 64'h0);

    // R3 and R7: sweep over modes, masks and all line patterns
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 4; k++) begin
        for (int l = 0; l < 256; l++) begin
          logic [7:0] im;
          logic       expP;
          im = (k == 0) ? 8'h00 : (k == 1) ? 8'h80 : (k == 2) ? 8'h3C : 8'hFF;
          irqLines = 8'(l);
          wrReg(2'd0, {48'h0, im, 5'h0, 3'(m)});
          expP = (m == 1) && ((8'(l) & im) != 8'h0);
          chk("R3 pending", 64'(irqPending), 64'(expP));
          step();
          if (expP) begin
            chk("R7 interrupt code", 64'(codeOf(causeOut)), 64'h0);
            chk("R7 pending cleared after entry", 64'(irqPending), 64'h0);
          end
        end
      end
    end
    irqLines = 8'h00;
    wrReg(2'd0, 64'h0);
    step();

    // R4 and R6: fresh entry with BEV clear
    excReq = 1'b1; excCode = 5'd10; excInDelay = 1'b1; curPc = 64'h1234;
    step();
    excReq = 1'b0;
    chk("R4 epc", epcOut, 64'h1234);
    chk("R4 bd", 64'(causeOut[31]), 64'h1);
    chk("R4 code", 64'(codeOf(causeOut)), 64'd10);
    chk("R4 exl", 64'(statusOut[1]), 64'h1);
    chk("R6 valid", 64'(redirectValid), 64'h1);
    chk("R6 general vector", redirectPc, GEN_V);
    step();
    chk("R6 valid pulse ends", 64'(redirectValid), 64'h0);

    // R5: nested entry
    excReq = 1'b1; excCode = 5'd3; excInDelay = 1'b0; curPc = 64'h9999;
    step();
    excReq = 1'b0;
    chk("R5 epc kept", epcOut, 64'h1234);
    chk("R5 bd kept", 64'(causeOut[31]), 64'h1);
    chk("R5 code", 64'(codeOf(causeOut)), 64'd3);

    // R8: return through EPC
    eretReq = 1'b1;
    step();
    eretReq = 1'b0;
    chk("R8 epc target", redirectPc, 64'h1234);
    chk("R8 valid", 64'(redirectValid), 64'h1);
    chk("R8 llClear", 64'(llClear), 64'h1);
    chk("R8 exl cleared", 64'(statusOut[1]), 64'h0);
    step();
    chk("R8 llClear pulse ends", 64'(llClear), 64'h0);

    // R6: boot vector
    wrReg(2'd0, 64'h0040_0000);
    excReq = 1'b1; excCode = 5'd4; curPc = 64'h40;
    step();
    excReq = 1'b0;
    chk("R6 boot vector", redirectPc, BEV_V);

    // R8: return through ErrorEPC, then EPC
    wrReg(2'd3, 64'hABC0);
    wrReg(2'd0, 64'h0040_0006);
    eretReq = 1'b1;
    step();
    chk("R8 error target", redirectPc, 64'hABC0);
    chk("R8 erl cleared", 64'(statusOut), 64'h0040_0002);
    chk("R8 llClear on erl", 64'(llClear), 64'h1);
    step();
    eretReq = 1'b0;
    chk("R8 second return", redirectPc, 64'h40);
    chk("R8 status after", 64'(statusOut), 64'h0040_0000);

    // R7: sync exception beats pending interrupt, then timer line taken
    irqLines = 8'h80;
    wrReg(2'd0, 64'h0000_8001);
    chk("R3 timer pending", 64'(irqPending), 64'h1);
    excReq = 1'b1; excCode = 5'd8; curPc = 64'h500;
    step();
    excReq = 1'b0;
    chk("R7 sync wins", 64'(codeOf(causeOut)), 64'd8);
    chk("R7 sync epc", epcOut, 64'h500);
    curPc = 64'h600; eretReq = 1'b1;
    step();
    eretReq = 1'b0;
    chk("R8 target", redirectPc, 64'h500);
    chk("R3 pending after return", 64'(irqPending), 64'h1);
    step();
    chk("R7 int code", 64'(codeOf(causeOut)), 64'h0);
    chk("R7 int epc", epcOut, 64'h600);
    chk("R7 int bd", 64'(causeOut[31]), 64'h0);
    chk("R7 int vector", redirectPc, GEN_V);

    // R9: exception and return together
    excReq = 1'b1; eretReq = 1'b1; excCode = 5'd12; curPc = 64'h700;
    step();
    excReq = 1'b0; eretReq = 1'b0;
    chk("R9 no llClear", 64'(llClear), 64'h0);
    chk("R9 code", 64'(codeOf(causeOut)), 64'd12);
    chk("R9 vector", redirectPc, GEN_V);
    chk("R9 exl kept", 64'(statusOut[1]), 64'h1);

    // R10: writes and dropped writes
    wrReg(2'd2, 64'h7777);
    chk("R10 epc write", epcOut, 64'h7777);
    irqLines = 8'h00;
    excReq = 1'b1; excCode = 5'd9;
    wrReg(2'd0, 64'h0);
    excReq = 1'b0;
    chk("R10 status write dropped", 64'(statusOut), 64'h0000_8003);
    eretReq = 1'b1;
    wrReg(2'd3, 64'h1);
    eretReq = 1'b0;
    chk("R10 errorEpc write dropped", errorEpcOut, 64'hABC0);
    chk("R10 return target", redirectPc, 64'h7777);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule